// File: doc/BRIEF.md
# Two-Port Synchronous Static Memory with Per-Port Read Latency

This block is a word-addressed memory with two fully symmetric access ports, called left and right. Either port can read or write any word on any clock edge, including the word the other port is touching in the same cycle. Address, control and write data are captured on the rising clock edge. Both ports run on one shared clock.

Each port picks its own read latency with a static mode input. Flow-through mode (mode = 0) presents the word one edge after the request. Pipelined mode (mode = 1) presents it one edge later than that.

Each port has an active-low and an active-high enable, which allows banking several instances without glue logic. Instead of a tristate pin, each port produces a `drive` flag, which is the enable for an external output buffer. The flag moves in step with the read data, and an active-low output-enable input can cut it off asynchronously. The default depth is 2K words of 9 bits; both dimensions are parameters.

Top module: `dpram_dual_sync`

## Requirements
- R1: A port is selected at an edge only when its `ce_n` is 0 and its `ce` is 1 at that edge. Any other combination performs no write, and the port's `drive` is 0 after that edge in flow-through mode.
- R2: A selected port with `wr_n` = 0 at an edge stores `wdata` at `addr`. A later read of that word returns it.
- R3: In flow-through mode (mode = 0), a selected read with `wr_n` = 1 sampled at edge n gives `drive` = 1 and `rdata` = the stored word after edge n.
- R4: In pipelined mode (mode = 1), the word read at edge n appears after edge n+1. After edge n itself, `drive` reflects the request sampled at edge n-1.
- R5: `oe_n` = 1 forces `drive` to 0 at once, with no clock edge. Returning `oe_n` to 0 restores `drive` at once.
- R6: When a deselect is sampled, `drive` stays at its current value until the next edge and falls after it.
- R7: The two ports' mode inputs are independent. The same word read on both ports at the same edge, with left in flow-through and right in pipelined mode, appears on left after edge n and on right after edge n+1.
- R8: A write on one port and a read of the same address on the other port at the same edge return the newly written word to the reader.
- R9: When both ports write the same address at the same edge, the left port's data is what remains stored.
- R10: A write cycle gives `drive` = 0 after its edge, even with `oe_n` = 0.
- R11: In pipelined mode, `drive` and `rdata` move through the extra stage together: `drive` is 1 exactly when `rdata` holds a requested word.
- R12: While `rst_n` is 0, and after it is released, both `drive` outputs are 0 until a read is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce_n | input | 1 | Left enable, active low |
| l_ce | input | 1 | Left enable, active high |
| l_wr_n | input | 1 | Left: 0 = write, 1 = read |
| l_oe_n | input | 1 | Left output enable, active low, asynchronous |
| l_pipe | input | 1 | Left mode: 0 = flow-through, 1 = pipelined |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data |
| l_drive | output | 1 | Left output-buffer enable |
| r_ce_n | input | 1 | Right enable, active low |
| r_ce | input | 1 | Right enable, active high |
| r_wr_n | input | 1 | Right: 0 = write, 1 = read |
| r_oe_n | input | 1 | Right output enable, active low, asynchronous |
| r_pipe | input | 1 | Right mode: 0 = flow-through, 1 = pipelined |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data |
| r_drive | output | 1 | Right output-buffer enable |

## Verification
The bench aims at the cases where the two ports or the two latencies meet:
- A same-edge write and read of one word across ports. A design that samples the array before the write lands would return the stale word.
- A same-edge double write. Without a fixed order, the right port's data could win.
- Deselect with each wrong enable polarity, while write is requested. A decoder that checks only one enable would corrupt the stored word.
- Deselect timing. A design that drops `drive` before the edge would fail the check taken between the deselect and the edge.
- Pipelined reads. A qualifier left un-delayed would raise `drive` one cycle before its data.
- Toggling `oe_n` between edges. A registered output enable would show no change until the next edge.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int NUM_PORTS = 2;
    localparam int PORT_L    = 0;
    localparam int PORT_R    = 1;

    typedef enum logic {
        LAT_FLOW = 1'b0,
        LAT_PIPE = 1'b1
    } lat_mode_e;

endpackage

// File: rtl/dpram_core.sv
module dpram_core #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9,
    parameter int NPORT  = 2
) (
    input  logic                          clk,
    input  logic [NPORT-1:0]              wr_en,
    input  logic [NPORT-1:0][ADDR_W-1:0]  wr_addr,
    input  logic [NPORT-1:0][DATA_W-1:0]  wr_data,
    input  logic [NPORT-1:0][ADDR_W-1:0]  rd_addr,
    output logic [NPORT-1:0][DATA_W-1:0]  rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Highest index written first, so port 0 (left) lands last and wins.
    always_ff @(posedge clk) begin
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (wr_en[p]) begin
                mem_q[wr_addr[p]] <= wr_data[p];
            end
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_rd
        assign rd_data[g] = mem_q[rd_addr[g]];
    end

endmodule

// File: rtl/dpram_port_ctl.sv
module dpram_port_ctl
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_i,
    input  logic              ce_i,
    input  logic              wr_n_i,
    input  logic              oe_n_i,
    input  lat_mode_e         mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              drive_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic [DATA_W-1:0] pdata;
        logic              prd;
    } port_state_t;

    port_state_t st_d, st_q;
    logic        sel;

    assign sel = ~ce_n_i & ce_i;

    always_comb begin
        st_d       = st_q;
        st_d.addr  = addr_i;
        st_d.rd    = sel & wr_n_i;
        st_d.pdata = mem_rdata_i;
        st_d.prd   = st_q.rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o   = sel & ~wr_n_i;
    assign rd_addr_o = st_q.addr;
    assign rdata_o   = (mode_i == LAT_PIPE) ? st_q.pdata : mem_rdata_i;
    assign drive_o   = ((mode_i == LAT_PIPE) ? st_q.prd : st_q.rd) & ~oe_n_i;

endmodule

// File: rtl/dpram_dual_sync.sv
module dpram_dual_sync
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_ce,
    input  logic              l_wr_n,
    input  logic              l_oe_n,
    input  logic              l_pipe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_drive,
    input  logic              r_ce_n,
    input  logic              r_ce,
    input  logic              r_wr_n,
    input  logic              r_oe_n,
    input  logic              r_pipe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_drive
);
    logic [NUM_PORTS-1:0]             ce_n_a, ce_a, wr_n_a, oe_n_a, pipe_a, wr_en_a, drive_a;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_a, rd_addr_a;
    logic [NUM_PORTS-1:0][DATA_W-1:0] wdata_a, mem_rd_a, rdata_a;

    assign ce_n_a  = {r_ce_n, l_ce_n};
    assign ce_a    = {r_ce,   l_ce};
    assign wr_n_a  = {r_wr_n, l_wr_n};
    assign oe_n_a  = {r_oe_n, l_oe_n};
    assign pipe_a  = {r_pipe, l_pipe};
    assign addr_a  = {r_addr, l_addr};
    assign wdata_a = {r_wdata, l_wdata};

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        dpram_port_ctl #(
            .ADDR_W(ADDR_W),
            .DATA_W(DATA_W)
        ) ctl_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .ce_n_i     (ce_n_a[g]),
            .ce_i       (ce_a[g]),
            .wr_n_i     (wr_n_a[g]),
            .oe_n_i     (oe_n_a[g]),
            .mode_i     (lat_mode_e'(pipe_a[g])),
            .addr_i     (addr_a[g]),
            .mem_rdata_i(mem_rd_a[g]),
            .wr_en_o    (wr_en_a[g]),
            .rd_addr_o  (rd_addr_a[g]),
            .rdata_o    (rdata_a[g]),
            .drive_o    (drive_a[g])
        );
    end

    dpram_core #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .NPORT (NUM_PORTS)
    ) core_i (
        .clk    (clk),
        .wr_en  (wr_en_a),
        .wr_addr(addr_a),
        .wr_data(wdata_a),
        .rd_addr(rd_addr_a),
        .rd_data(mem_rd_a)
    );

    assign l_rdata = rdata_a[PORT_L];
    assign r_rdata = rdata_a[PORT_R];
    assign l_drive = drive_a[PORT_L];
    assign r_drive = drive_a[PORT_R];

endmodule

// File: rtl/dpram_dual_sync_chk.sv
module dpram_dual_sync_chk (
    input logic clk,
    input logic rst_n,
    input logic l_ce_n,
    input logic l_ce,
    input logic l_wr_n,
    input logic l_oe_n,
    input logic l_pipe,
    input logic l_drive,
    input logic r_ce_n,
    input logic r_ce,
    input logic r_wr_n,
    input logic r_oe_n,
    input logic r_pipe,
    input logic r_drive
);
    logic l_sel, r_sel;
    assign l_sel = ~l_ce_n & l_ce;
    assign r_sel = ~r_ce_n & r_ce;

    assert_oe_cut_l_R5: assert property (@(posedge clk) disable iff (!rst_n)
        l_oe_n |-> !l_drive);
    assert_oe_cut_r_R5: assert property (@(posedge clk) disable iff (!rst_n)
        r_oe_n |-> !r_drive);

    assert_desel_l_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sel && !l_pipe) |=> (!l_drive || l_pipe));
    assert_desel_r_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_sel && !r_pipe) |=> (!r_drive || r_pipe));

    assert_wr_turn_l_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && !l_wr_n && !l_pipe) |=> (!l_drive || l_pipe));
    assert_wr_turn_r_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_sel && !r_wr_n && !r_pipe) |=> (!r_drive || r_pipe));

    assert_flow_rd_l_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && l_wr_n && !l_pipe && !l_oe_n) |=> (l_drive || l_pipe || l_oe_n));

    assert_pipe_lag_r_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_pipe && !(r_sel && r_wr_n)) |=> ##1 (!r_drive || !r_pipe));

endmodule

bind dpram_dual_sync dpram_dual_sync_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .l_ce_n (l_ce_n),
    .l_ce   (l_ce),
    .l_wr_n (l_wr_n),
    .l_oe_n (l_oe_n),
    .l_pipe (l_pipe),
    .l_drive(l_drive),
    .r_ce_n (r_ce_n),
    .r_ce   (r_ce),
    .r_wr_n (r_wr_n),
    .r_oe_n (r_oe_n),
    .r_pipe (r_pipe),
    .r_drive(r_drive)
);

// File: tb/dpram_dual_sync_tb_top.sv
module dpram_dual_sync_tb_top;
    localparam int AW = 11;
    localparam int DW = 9;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          l_ce_n, l_ce, l_wr_n, l_oe_n, l_pipe;
    logic [AW-1:0] l_addr;
    logic [DW-1:0] l_wdata, l_rdata;
    logic          l_drive;
    logic          r_ce_n, r_ce, r_wr_n, r_oe_n, r_pipe;
    logic [AW-1:0] r_addr;
    logic [DW-1:0] r_wdata, r_rdata;
    logic          r_drive;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // {address, data} pairs; written on left, read back on right
    localparam logic [AW+DW-1:0] VEC [0:7] = '{
        {11'h000, 9'h1A5}, {11'h7FF, 9'h05A}, {11'h010, 9'h0F0}, {11'h011, 9'h10F},
        {11'h3C3, 9'h1FF}, {11'h400, 9'h000}, {11'h123, 9'h155}, {11'h2AA, 9'h0AA}
    };

    always #5 clk = ~clk;

    dpram_dual_sync #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_ce(l_ce), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_pipe(l_pipe),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_drive(l_drive),
        .r_ce_n(r_ce_n), .r_ce(r_ce), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_pipe(r_pipe),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_drive(r_drive)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic l_set(input logic cen, input logic ce, input logic wrn,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_ce_n = cen; l_ce = ce; l_wr_n = wrn; l_addr = a; l_wdata = d;
    endtask

    task automatic r_set(input logic cen, input logic ce, input logic wrn,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_ce_n = cen; r_ce = ce; r_wr_n = wrn; r_addr = a; r_wdata = d;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0;
        l_oe_n = 1'b0; r_oe_n = 1'b0; l_pipe = 1'b0; r_pipe = 1'b0;
        l_set(1, 0, 1, '0, '0);
        r_set(1, 0, 1, '0, '0);
        repeat (3) @(negedge clk);
        chk("R12 reset l_drive", 32'(l_drive), 0);
        chk("R12 reset r_drive", 32'(r_drive), 0);
        rst_n = 1'b1;
        tick();
        chk("R12 post-reset r_drive", 32'(r_drive), 0);

        // Table walk: R2 write on left, R3 flow read on right
        for (int i = 0; i < 8; i++) begin
            l_set(0, 1, 0, VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
            tick();
            chk("R10 l_drive after write", 32'(l_drive), 0);
        end
        l_set(1, 0, 1, '0, '0);
        for (int i = 0; i < 8; i++) begin
            r_set(0, 1, 1, VEC[i][AW+DW-1:DW], '0);
            tick();
            chk("R3 r_drive", 32'(r_drive), 1);
            chk("R2 r_rdata", 32'(r_rdata), 32'(VEC[i][DW-1:0]));
        end
        r_set(1, 0, 1, '0, '0);
        tick();
        chk("R1 r_drive after deselect", 32'(r_drive), 0);

        // R1: deselected writes with each wrong enable polarity do nothing
        l_set(1, 1, 0, 11'h010, 9'h033);
        tick();
        l_set(0, 0, 0, 11'h010, 9'h044);
        tick();
        l_set(1, 0, 1, '0, '0);
        r_set(0, 1, 1, 11'h010, '0);
        tick();
        chk("R1 no write when deselected", 32'(r_rdata), 32'h0F0);

        // R5: asynchronous output enable
        r_oe_n = 1'b1;
        #1;
        chk("R5 oe_n high cuts drive", 32'(r_drive), 0);
        r_oe_n = 1'b0;
        #1;
        chk("R5 oe_n low restores drive", 32'(r_drive), 1);

        // R6: deselect takes effect only after the next edge
        r_set(1, 0, 1, '0, '0);
        #1;
        chk("R6 drive held before edge", 32'(r_drive), 1);
        tick();
        chk("R6 drive low after edge", 32'(r_drive), 0);

        // R4/R11: pipelined latency on right
        r_pipe = 1'b1;
        r_set(0, 1, 1, 11'h3C3, '0);
        tick();
        chk("R4 pipe drive not yet", 32'(r_drive), 0);
        r_set(1, 0, 1, '0, '0);
        tick();
        chk("R11 pipe drive aligned", 32'(r_drive), 1);
        chk("R4 pipe data", 32'(r_rdata), 32'h1FF);
        tick();
        chk("R11 pipe drive falls", 32'(r_drive), 0);

        // R7: left flow, right pipe, same word same edge
        l_set(0, 1, 1, 11'h123, '0);
        r_set(0, 1, 1, 11'h123, '0);
        tick();
        l_set(1, 0, 1, '0, '0);
        r_set(1, 0, 1, '0, '0);
        chk("R7 left flow drive", 32'(l_drive), 1);
        chk("R7 left flow data", 32'(l_rdata), 32'h155);
        chk("R7 right pipe not yet", 32'(r_drive), 0);
        tick();
        chk("R7 right pipe drive", 32'(r_drive), 1);
        chk("R7 right pipe data", 32'(r_rdata), 32'h155);
        r_pipe = 1'b0;

        // R8: write left, read right same address same edge
        l_set(0, 1, 0, 11'h2AA, 9'h13C);
        r_set(0, 1, 1, 11'h2AA, '0);
        tick();
        chk("R8 cross-port new data", 32'(r_rdata), 32'h13C);
        chk("R10 writer drive low", 32'(l_drive), 0);

        // R9: both write the same address, left must win
        l_set(0, 1, 0, 11'h400, 9'h0C3);
        r_set(0, 1, 0, 11'h400, 9'h13D);
        tick();
        l_set(1, 0, 1, '0, '0);
        r_set(0, 1, 1, 11'h400, '0);
        tick();
        chk("R9 left priority", 32'(r_rdata), 32'h0C3);
        r_set(1, 0, 1, '0, '0);
        tick();

        done = 1'b1;
        summary();
    end

endmodule